// File: doc/BRIEF.md
# Drive Link Status and Command Sequencer

This block runs the periodic word exchange between a sub processor and an optical drive controller. Software sets a sticky enable bit, which turns on the link clock toward the drive. One frame period later, and every period after that, the block opens a receive window. It announces the window with a one-cycle `frame_req` pulse and stores the ten 4-bit status words the drive returns. Once the seventh word is stored, the block raises an interrupt. It does not wait for the last three words, which carry the checksum.

Software places ten command words in the command registers. Writing the last of them starts an upload that sends all ten words out on the command port, one word per cycle. A frame tick that falls due while an upload is pending or running is held back. Its receive window opens once the upload has finished. The block does not interpret the meaning of any word.

Top module: `drv_link_ctrl`

## Requirements
- R1: After reset, `irq`, `frame_req`, `cmd_valid` and `link_clk_on` are 0, and the control register (address 0) reads 0.
- R2: Writing address 0 with bit 2 set turns on the enable, which reads back as bit 2 of address 0 and drives `link_clk_on`. Once set, the enable is cleared only by reset: writing 0 to bit 2 does not clear it, reading does not clear it, and frame activity does not clear it.
- R3: The first `frame_req` pulse comes between FRAME_CLKS and FRAME_CLKS+3 cycles after the enabling write. While the block is idle, successive pulses are exactly FRAME_CLKS cycles apart.
- R4: After a `frame_req`, the next ten cycles with `sts_valid` high store `sts_word` as status words 0 to 9, in arrival order. Status word k reads back at address 16+k.
- R5: `irq` is 1 in the cycle after the seventh status word of a frame is strobed, and it is still 0 after the sixth.
- R6: `irq` holds until software writes address 0 with bit 0 set. Bit 0 of address 0 reads the interrupt flag.
- R7: Command word k is written at address 16+k. Writing address 25 (word 9) makes `cmd_valid` high for exactly ten consecutive cycles, carrying words 0 to 9 in order.
- R8: `frame_req` is never high while `cmd_valid` is high. A frame tick that falls due during a pending or running upload opens its window only after the last command word has been sent.
- R9: While the enable is clear, no `frame_req` occurs, `irq` stays 0, and `sts_valid` strobes are not stored.
- R10: `sts_valid` strobes outside a receive window leave the stored status words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: 0 is control, 16+k is word k |
| reg_wdata | input | WORD_W | Write data |
| reg_rdata | output | WORD_W | Combinational read data for `reg_addr` |
| link_clk_on | output | 1 | Link clock enable toward the drive |
| frame_req | output | 1 | One-cycle pulse that opens a status receive window |
| sts_valid | input | 1 | Status word strobe from the drive |
| sts_word | input | WORD_W | Status word from the drive |
| cmd_valid | output | 1 | Command word strobe toward the drive |
| cmd_word | output | WORD_W | Command word toward the drive |
| irq | output | 1 | Drive interrupt request |

## Verification
The assertions assume that the drive sends no more than ten words per window and keeps `sts_valid` low outside the windows it has been granted. The one exception is the deliberate stray strobes that test R9 and R10. They also assume that software acknowledges the interrupt only through address 0.

The stimulus answers each `frame_req` with exactly ten words, sometimes with idle gaps between them. It writes the last command word only while no upload is running. It times one such write to land a few cycles before a frame tick, so that a tick falls due during an upload and is held back.

// File: rtl/drv_link_pkg.sv
package drv_link_pkg;
   typedef enum logic [1:0] {
      LK_IDLE = 2'd0,
      LK_RX   = 2'd1,
      LK_TX   = 2'd2
   } lk_state_e;
endpackage

// File: rtl/drv_frame_timer.sv
module drv_frame_timer #(
   parameter int FRAME_CLKS = 225792
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CNT_W = (FRAME_CLKS > 1) ? $clog2(FRAME_CLKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CLKS - 1);

   logic [CNT_W-1:0] cnt;

   generate
      if (FRAME_CLKS < 2) begin : g_bad
         $error("FRAME_CLKS must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt == LAST) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R3
endmodule

// File: rtl/drv_sts_rx.sv
module drv_sts_rx #(
   parameter int WORD_W  = 4,
   parameter int N_WORDS = 10,
   parameter int IRQ_AT  = 7
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      sts_valid,
   input  logic [WORD_W-1:0]         sts_word,
   output logic                      busy,
   output logic                      hit,
   output logic                      done,
   output logic [N_WORDS*WORD_W-1:0] words
);
   localparam int IDX_W = $clog2(N_WORDS);
   localparam logic [IDX_W-1:0] HIT_IDX  = IDX_W'(IRQ_AT - 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

   logic [IDX_W-1:0] idx;
   logic             take;

   assign take = busy && sts_valid;
   assign hit  = take && (idx == HIT_IDX);
   assign done = take && (idx == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         idx  <= '0;
      end else if (take) begin
         idx <= idx + 1'b1;
         if (idx == LAST_IDX) busy <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         words <= '0;
      end else begin
         for (int g = 0; g < N_WORDS; g++) begin
            if (take && idx == IDX_W'(g)) words[g*WORD_W +: WORD_W] <= sts_word;
         end
      end
   end

   AST_RX_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (idx <= LAST_IDX)); // R4
   AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(words)); // R10
endmodule

// File: rtl/drv_cmd_tx.sv
module drv_cmd_tx #(
   parameter int WORD_W  = 4,
   parameter int N_WORDS = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [N_WORDS*WORD_W-1:0] words,
   output logic                      busy,
   output logic                      done,
   output logic [WORD_W-1:0]         cmd_word
);
   localparam int IDX_W = $clog2(N_WORDS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

   logic [IDX_W-1:0] idx;

   assign done = busy && (idx == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         idx  <= '0;
      end else if (busy) begin
         idx <= idx + 1'b1;
         if (idx == LAST_IDX) busy <= 1'b0;
      end
   end

   always_comb begin
      cmd_word = '0;
      for (int g = 0; g < N_WORDS; g++) begin
         if (busy && idx == IDX_W'(g)) cmd_word = words[g*WORD_W +: WORD_W];
      end
   end

   AST_TX_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy); // R7
endmodule

// File: rtl/drv_link_ctrl.sv
module drv_link_ctrl #(
   parameter int ADDR_W     = 5,
   parameter int WORD_W     = 4,
   parameter int N_WORDS    = 10,
   parameter int IRQ_AT     = 7,
   parameter int FRAME_CLKS = 225792,
   parameter int EN_BIT     = 2,
   parameter int ACK_BIT    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              link_clk_on,
   output logic              frame_req,
   input  logic              sts_valid,
   input  logic [WORD_W-1:0] sts_word,
   output logic              cmd_valid,
   output logic [WORD_W-1:0] cmd_word,
   output logic              irq
);
   import drv_link_pkg::*;

   localparam int SEL_W = ADDR_W - 1;
   localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(N_WORDS - 1);

   generate
      if (IRQ_AT < 1 || IRQ_AT > N_WORDS) begin : g_bad_irq
         $error("IRQ_AT must lie within the frame");
      end
      if (N_WORDS > (1 << SEL_W) || N_WORDS < 2) begin : g_bad_words
         $error("N_WORDS does not fit the word address space");
      end
      if (EN_BIT >= WORD_W || ACK_BIT >= WORD_W || EN_BIT == ACK_BIT) begin : g_bad_bits
         $error("control bit positions invalid");
      end
   endgenerate

   lk_state_e st;
   logic enable, irq_pend, cmd_pend, tick_pend, tick;
   logic start_rx, start_tx;
   logic rx_busy, rx_hit, rx_done, tx_busy, tx_done;
   logic [N_WORDS*WORD_W-1:0] sts_q, cmd_q;
   logic ctrl_wr, word_wr, ack_wr;
   logic [SEL_W-1:0] sel;

   assign sel     = reg_addr[SEL_W-1:0];
   assign ctrl_wr = reg_we && (reg_addr == '0);
   assign word_wr = reg_we && reg_addr[ADDR_W-1];
   assign ack_wr  = ctrl_wr && reg_wdata[ACK_BIT];

   assign start_tx = (st == LK_IDLE) && cmd_pend;
   assign start_rx = (st == LK_IDLE) && !cmd_pend && tick_pend;

   drv_frame_timer #(.FRAME_CLKS(FRAME_CLKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(enable), .tick(tick));

   drv_sts_rx #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .IRQ_AT(IRQ_AT)) u_rx (
      .clk(clk), .rst_n(rst_n), .start(start_rx), .sts_valid(sts_valid),
      .sts_word(sts_word), .busy(rx_busy), .hit(rx_hit), .done(rx_done),
      .words(sts_q));

   drv_cmd_tx #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(start_tx), .words(cmd_q),
      .busy(tx_busy), .done(tx_done), .cmd_word(cmd_word));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable    <= 1'b0;
         irq_pend  <= 1'b0;
         cmd_pend  <= 1'b0;
         tick_pend <= 1'b0;
         frame_req <= 1'b0;
         st        <= LK_IDLE;
      end else begin
         if (ctrl_wr && reg_wdata[EN_BIT]) enable <= 1'b1;
         if (rx_hit)      irq_pend <= 1'b1;
         else if (ack_wr) irq_pend <= 1'b0;
         if (word_wr && sel == LAST_SEL) cmd_pend <= 1'b1;
         else if (start_tx)              cmd_pend <= 1'b0;
         if (tick)          tick_pend <= 1'b1;
         else if (start_rx) tick_pend <= 1'b0;
         frame_req <= start_rx;
         unique case (st)
            LK_IDLE: if (start_tx) st <= LK_TX; else if (start_rx) st <= LK_RX;
            LK_TX:   if (tx_done) st <= LK_IDLE;
            LK_RX:   if (rx_done) st <= LK_IDLE;
            default: st <= LK_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else begin
         for (int g = 0; g < N_WORDS; g++) begin
            if (word_wr && sel == SEL_W'(g)) cmd_q[g*WORD_W +: WORD_W] <= reg_wdata;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == '0) begin
         reg_rdata[EN_BIT]  = enable;
         reg_rdata[ACK_BIT] = irq_pend;
      end else if (reg_addr[ADDR_W-1]) begin
         for (int g = 0; g < N_WORDS; g++) begin
            if (sel == SEL_W'(g)) reg_rdata = sts_q[g*WORD_W +: WORD_W];
         end
      end
   end

   assign link_clk_on = enable;
   assign cmd_valid   = tx_busy;
   assign irq         = irq_pend;

   AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> enable); // R2
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!frame_req && !irq && !rx_busy)); // R9
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend && !ack_wr) |=> irq_pend); // R6
   AST_RX_TX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_busy && tx_busy)); // R8
   AST_NO_FRAME_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_req && cmd_valid)); // R8
endmodule

// File: tb/drv_link_ctrl_bench.sv
`timescale 1ns/1ps
module drv_link_ctrl_bench;
   localparam int F = 300;
   localparam int N = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [4:0] reg_addr = '0;
   logic [3:0] reg_wdata = '0;
   logic [3:0] reg_rdata;
   logic       link_clk_on, frame_req, cmd_valid, irq;
   logic       sts_valid = 1'b0;
   logic [3:0] sts_word = '0;
   logic [3:0] cmd_word;

   int total = 0, bad = 0, cyc = 0;
   int fr_count = 0, cmd_popped = 0, cmd_last = 0, run_len = 0;
   int fr_t [16];
   logic [3:0] exp_q [$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   drv_link_ctrl #(.FRAME_CLKS(F)) u_drv_link_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_clk_on(link_clk_on),
      .frame_req(frame_req), .sts_valid(sts_valid), .sts_word(sts_word),
      .cmd_valid(cmd_valid), .cmd_word(cmd_word), .irq(irq));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Scoreboard monitor: command words, frame pulses, burst length
   always @(negedge clk) begin
      if (rst_n) begin
         if (frame_req) begin
            if (fr_count < 16) fr_t[fr_count] = cyc;
            fr_count++;
            check(!cmd_valid, "R8 frame during upload", 1, 0);
         end
         if (cmd_valid) begin
            run_len++;
            cmd_last = cyc;
            if (exp_q.size() == 0) check(0, "R7 unexpected command word", int'(cmd_word), -1);
            else begin
               logic [3:0] e;
               e = exp_q.pop_front();
               cmd_popped++;
               check(cmd_word == e, "R7 command word", int'(cmd_word), int'(e));
            end
         end else if (run_len != 0) begin
            check(run_len == N, "R7 burst length", run_len, N);
            run_len = 0;
         end
      end
   end

   task automatic reg_write(input logic [4:0] a, input logic [3:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = '0;
   endtask

   task automatic reg_read(input logic [4:0] a, output logic [3:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // Driver: load words, and on the last one push the expected burst
   task automatic send_cmds(input logic [3:0] base, input bit last_now);
      for (int k = 0; k < N - 1; k++) reg_write(5'(16 + k), 4'(base + k * 3));
      if (last_now) begin
         for (int k = 0; k < N; k++) exp_q.push_back(4'(base + k * 3));
         reg_write(5'(16 + N - 1), 4'(base + (N - 1) * 3));
      end
   endtask

   task automatic serve_frame(input logic [3:0] base, input bit chk_irq);
      while (!frame_req) @(negedge clk);
      for (int k = 0; k < N; k++) begin
         sts_valid = 1'b1; sts_word = 4'(base + k * 5);
         @(negedge clk);
         sts_valid = 1'b0;
         if (chk_irq && k == 5) check(irq == 1'b0, "R5 irq after sixth word", int'(irq), 0);
         if (chk_irq && k == 6) check(irq == 1'b1, "R5 irq after seventh word", int'(irq), 1);
         if (k % 3 == 1) @(negedge clk);
      end
   endtask

   task automatic check_status(input logic [3:0] base, input string req);
      logic [3:0] d;
      for (int k = 0; k < N; k++) begin
         reg_read(5'(16 + k), d);
         check(d == 4'(base + k * 5), req, int'(d), int'(4'(base + k * 5)));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [3:0] d;
      int c_en, t_due;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      reg_read(5'd0, d);
      check(d == 4'd0, "R1 control reads zero", int'(d), 0);
      check(!irq && !frame_req && !cmd_valid && !link_clk_on, "R1 outputs idle",
            int'({irq, frame_req, cmd_valid, link_clk_on}), 0);

      // R9 disabled: strobes ignored, no frames, no irq
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); sts_valid = 1'b1; sts_word = 4'd9;
      end
      @(negedge clk); sts_valid = 1'b0;
      repeat (2 * F) @(negedge clk);
      check(fr_count == 0, "R9 no frame while disabled", fr_count, 0);
      check(irq == 1'b0, "R9 no irq while disabled", int'(irq), 0);
      reg_read(5'd16, d);
      check(d == 4'd0, "R9 strobe not stored", int'(d), 0);

      // R2 / R3 enable and first frame timing
      reg_write(5'd0, 4'b0100);
      c_en = cyc;
      check(link_clk_on == 1'b1, "R2 link clock on", int'(link_clk_on), 1);
      reg_read(5'd0, d);
      check(d == 4'b0100, "R2 enable reads back", int'(d), 4);
      serve_frame(4'd1, 1'b1);
      check(fr_t[0] - c_en >= F && fr_t[0] - c_en <= F + 3, "R3 first frame delay",
            fr_t[0] - c_en, F + 2);
      check_status(4'd1, "R4 status words frame 1");
      reg_read(5'd0, d);
      check(d[0] == 1'b1, "R6 irq flag reads", int'(d[0]), 1);
      repeat (20) @(negedge clk);
      check(irq == 1'b1, "R6 irq held", int'(irq), 1);
      reg_write(5'd0, 4'b0000);
      reg_read(5'd0, d);
      check(d == 4'b0101, "R2 zero write keeps enable, no ack", int'(d), 5);
      reg_write(5'd0, 4'b0001);
      reg_read(5'd0, d);
      check(d == 4'b0100, "R6 ack clears irq, R2 enable kept", int'(d), 4);
      check(irq == 1'b0, "R6 irq low after ack", int'(irq), 0);

      // R10 stray strobe outside window
      @(negedge clk); sts_valid = 1'b1; sts_word = 4'hF;
      @(negedge clk); sts_valid = 1'b0;
      reg_read(5'd16, d);
      check(d == 4'd1, "R10 stray strobe ignored", int'(d), 1);

      // frame 2: periodic interval, new pattern
      serve_frame(4'd7, 1'b1);
      check(fr_t[1] - fr_t[0] == F, "R3 frame period", fr_t[1] - fr_t[0], F);
      check_status(4'd7, "R4 status words frame 2");
      reg_write(5'd0, 4'b0001);
      send_cmds(4'd2, 1'b0);

      // R8 upload collides with the next frame tick
      t_due = fr_t[1] + F;
      while (cyc < t_due - 7) @(negedge clk);
      for (int k = 0; k < N; k++) exp_q.push_back(4'(2 + k * 3));
      reg_write(5'(16 + N - 1), 4'(2 + (N - 1) * 3));
      serve_frame(4'd3, 1'b1);
      check(fr_t[2] > cmd_last, "R8 frame after last command word", fr_t[2], cmd_last + 1);
      check(fr_t[2] > t_due, "R8 frame held back", fr_t[2], t_due + 1);
      check(cmd_popped == N, "R7 first burst complete", cmd_popped, N);
      check_status(4'd3, "R4 status words frame 3");
      reg_write(5'd0, 4'b0001);

      // R7 second pattern while idle
      send_cmds(4'd11, 1'b1);
      repeat (15) @(negedge clk);
      check(cmd_popped == 2 * N, "R7 second burst complete", cmd_popped, 2 * N);
      check(exp_q.size() == 0, "R7 scoreboard empty", exp_q.size(), 0);
      reg_read(5'd0, d);
      check(d[2] == 1'b1, "R2 enable survives frames", int'(d[2]), 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule